// File: doc/BRIEF.md
# Ring-Phase Hardwired Instruction Sequencer

This block sequences a small 8-bit processor whose instructions are 16 bits wide. A one-hot ring of eight phase flops walks each instruction through its steps. The first two phases fetch the instruction one byte at a time from the data bus into a high and a low instruction register. The remaining phases execute the instruction. A 4-bit opcode in the top nibble of the high byte is decoded by bitwise AND matching. Every control action is the AND of one opcode line with one phase line.

The output is a 32-bit control word with a fixed layout. It steers memory, the instruction pointer, the register file, the ALU operand registers, a scratch register (TMP) and a clock-stop line. Register indices are taken from the instruction nibbles and placed into the control word. All other bits are constants for the given phase. When an instruction has finished, the ring returns to phase 0 instead of advancing.

The fetch-low phase also loads TMP from the data bus. Load-immediate therefore moves its value from TMP into the register file.

Top module: `ring_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it is released, the ring is in phase 0 and both instruction registers read 0x00.
- R2: Phase 0 word = 0x00800182 (IP drives address bus bit 8, memory read bit 1, high-byte write bit 23, IP count bit 7), and the data byte is captured into the high register. Phase 1 word = 0x03000182 (low-byte write bit 24, TMP write bit 25 instead of bit 23), and the data byte is captured into the low register. Outside these phases the data input is ignored.
- R3: Opcode 0x1 (halt). Phase 2 drives only bit 31 (stop clock), and the ring stays in that phase until reset.
- R4: Opcode 0x2 (load indirect; destination = high-byte low nibble D, address register = low-byte high nibble A). Phase 2 = 0x02000C02 | A<<12. Phase 3 = 0x04000200 | D<<12. Then phase 0 follows.
- R5: Opcode 0x3 (store indirect; address register = high-byte low nibble A, source = low-byte high nibble S). Phase 2 = 0x02000400 | S<<12. Phase 3 = 0x04000C01 | A<<12. Then phase 0 follows.
- R6: Opcode 0x4 (load immediate; destination D = high-byte low nibble). Phase 2 = 0x04000200 | D<<12. Then phase 0 follows.
- R7: Opcode 0x5 (add; destination D = high-byte low nibble, sources X = low-byte high nibble and Y = low-byte low nibble). Phase 2 = 0x00200400 | X<<12. Phase 3 = 0x00400400 | Y<<12. Phase 4 = 0x00010200 | D<<12, with ALU function bits 20:17 = 0 (add). Then phase 0 follows.
- R8: Any other opcode (0x0, 0x6 to 0xF) gives an all-zero word in phase 2, and the ring then returns to phase 0.
- R9: Reserved bits 5:2 and 30:27, and IP write bit 6, are always 0.
- R10: Exactly one phase is active at any time, and the cycle after an instruction's last phase is a fetch of the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Data bus byte |
| ctrl_word | output | 32 | Control word for the current phase |
| instr_hi | output | 8 | High instruction byte (opcode and first field) |
| instr_lo | output | 8 | Low instruction byte (second and third fields) |

## Verification
The bench builds the block with its default parameters: an 8-phase ring, 8-bit bytes and a 4-bit opcode. This covers all sixteen opcode values and every phase that any instruction uses.

Random opcode and nibble streams cover every register index in each inserted field. Random bytes are also driven during execute phases, which shows that they are ignored. Directed cases cover a short program, unknown opcodes placed directly after other instructions, and a halt held for several cycles before reset.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;
    localparam int CW_W = 32;

    // control word bit positions (fixed layout decoded by the datapath)
    localparam int B_MEM_WR  = 0;
    localparam int B_MEM_RD  = 1;
    localparam int B_IP_WR   = 6;
    localparam int B_IP_CNT  = 7;
    localparam int B_IP_ADR  = 8;
    localparam int B_RF_WR   = 9;
    localparam int B_RF_RD   = 10;
    localparam int B_RF_ASEL = 11;
    localparam int B_RF_IDX  = 12;
    localparam int B_ALU_OE  = 16;
    localparam int B_ALU_FN  = 17;
    localparam int B_ALU_AW  = 21;
    localparam int B_ALU_BW  = 22;
    localparam int B_IRH_WR  = 23;
    localparam int B_IRL_WR  = 24;
    localparam int B_TMP_WR  = 25;
    localparam int B_TMP_RD  = 26;
    localparam int B_STOP    = 31;

    localparam logic [CW_W-1:0] RSVD_MASK = 32'h7800_007C;

    typedef enum logic [3:0] {
        OPC_HALT = 4'h1,
        OPC_LDR  = 4'h2,
        OPC_STR  = 4'h3,
        OPC_LDI  = 4'h4,
        OPC_ADD  = 4'h5
    } opc_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } ibuf_t;
endpackage

// File: rtl/phase_ring.sv
module phase_ring #(
    parameter int N_PHASE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               done,
    input  logic               hold,
    output logic [N_PHASE-1:0] phase
);
    localparam logic [N_PHASE-1:0] START = N_PHASE'(1);

    logic [N_PHASE-1:0] phase_d, phase_q;

    always_comb begin
        if (done)
            phase_d = START;
        else if (hold)
            phase_d = phase_q;
        else
            phase_d = {phase_q[N_PHASE-2:0], phase_q[N_PHASE-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= START;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R10
    ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(phase_q) == 1);

    // R10
    ring_restart_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> phase_q[0]);
endmodule

// File: rtl/opc_match.sv
module opc_match #(
    parameter int OPC_W = 4
) (
    input  logic [OPC_W-1:0]      opc,
    output logic [(1<<OPC_W)-1:0] hit
);
    localparam int N_OPC = 1 << OPC_W;

    for (genvar k = 0; k < N_OPC; k++) begin : g_line
        localparam logic [OPC_W-1:0] PAT = OPC_W'(k);
        assign hit[k] = &(opc ~^ PAT);
    end
endmodule

// File: rtl/cw_cells.sv
module cw_cells
    import ring_seq_pkg::*;
#(
    parameter int N_PHASE = 8,
    parameter int OPC_W   = 4
) (
    input  logic [N_PHASE-1:0]      phase,
    input  logic [(1<<OPC_W)-1:0]   hit,
    input  ibuf_t                   ib,
    output logic [CW_W-1:0]         cw,
    output logic                    done,
    output logic                    hold
);
    logic [3:0] f_dst, f_x, f_y;
    logic       known;

    assign f_dst = ib.hi[3:0];
    assign f_x   = ib.lo[7:4];
    assign f_y   = ib.lo[3:0];
    assign known = hit[OPC_HALT] | hit[OPC_LDR] | hit[OPC_STR]
                 | hit[OPC_LDI]  | hit[OPC_ADD];

    always_comb begin
        cw   = '0;
        done = 1'b0;
        hold = 1'b0;
        // shared fetch phases
        if (phase[0]) begin
            cw[B_IP_ADR] = 1'b1; cw[B_MEM_RD] = 1'b1;
            cw[B_IP_CNT] = 1'b1; cw[B_IRH_WR] = 1'b1;
        end
        if (phase[1]) begin
            cw[B_IP_ADR] = 1'b1; cw[B_MEM_RD] = 1'b1;
            cw[B_IP_CNT] = 1'b1; cw[B_IRL_WR] = 1'b1;
            cw[B_TMP_WR] = 1'b1;
        end
        // halt
        if (hit[OPC_HALT] && phase[2]) begin
            cw[B_STOP] = 1'b1;
            hold       = 1'b1;
        end
        // load indirect
        if (hit[OPC_LDR] && phase[2]) begin
            cw[B_RF_RD] = 1'b1; cw[B_RF_ASEL] = 1'b1;
            cw[B_RF_IDX +: 4] = f_x;
            cw[B_MEM_RD] = 1'b1; cw[B_TMP_WR] = 1'b1;
        end
        if (hit[OPC_LDR] && phase[3]) begin
            cw[B_TMP_RD] = 1'b1; cw[B_RF_WR] = 1'b1;
            cw[B_RF_IDX +: 4] = f_dst;
            done = 1'b1;
        end
        // store indirect
        if (hit[OPC_STR] && phase[2]) begin
            cw[B_RF_RD] = 1'b1; cw[B_RF_IDX +: 4] = f_x;
            cw[B_TMP_WR] = 1'b1;
        end
        if (hit[OPC_STR] && phase[3]) begin
            cw[B_RF_RD] = 1'b1; cw[B_RF_ASEL] = 1'b1;
            cw[B_RF_IDX +: 4] = f_dst;
            cw[B_TMP_RD] = 1'b1; cw[B_MEM_WR] = 1'b1;
            done = 1'b1;
        end
        // load immediate (value staged in TMP during fetch)
        if (hit[OPC_LDI] && phase[2]) begin
            cw[B_TMP_RD] = 1'b1; cw[B_RF_WR] = 1'b1;
            cw[B_RF_IDX +: 4] = f_dst;
            done = 1'b1;
        end
        // add
        if (hit[OPC_ADD] && phase[2]) begin
            cw[B_RF_RD] = 1'b1; cw[B_RF_IDX +: 4] = f_x;
            cw[B_ALU_AW] = 1'b1;
        end
        if (hit[OPC_ADD] && phase[3]) begin
            cw[B_RF_RD] = 1'b1; cw[B_RF_IDX +: 4] = f_y;
            cw[B_ALU_BW] = 1'b1;
        end
        if (hit[OPC_ADD] && phase[4]) begin
            cw[B_ALU_OE] = 1'b1;
            cw[B_ALU_FN +: 4] = 4'(ib.hi[7:4] - OPC_ADD);
            cw[B_RF_WR] = 1'b1; cw[B_RF_IDX +: 4] = f_dst;
            done = 1'b1;
        end
        // unrecognised opcode: nothing driven, straight back to fetch
        if (!known && phase[2])
            done = 1'b1;
    end
endmodule

// File: rtl/ring_seq_ctrl.sv
module ring_seq_ctrl
    import ring_seq_pkg::*;
#(
    parameter int N_PHASE = 8,
    parameter int BYTE_W  = 8,
    parameter int OPC_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CW_W-1:0]   ctrl_word,
    output logic [BYTE_W-1:0] instr_hi,
    output logic [BYTE_W-1:0] instr_lo
);
    localparam int N_OPC = 1 << OPC_W;

    ibuf_t              ib_d, ib_q;
    logic [N_PHASE-1:0] phase;
    logic [N_OPC-1:0]   hit;
    logic               done, hold;

    phase_ring #(.N_PHASE(N_PHASE)) u_ring (
        .clk(clk), .rst(rst), .done(done), .hold(hold), .phase(phase)
    );

    opc_match #(.OPC_W(OPC_W)) u_match (
        .opc(ib_q.hi[BYTE_W-1 -: OPC_W]), .hit(hit)
    );

    cw_cells #(.N_PHASE(N_PHASE), .OPC_W(OPC_W)) u_cells (
        .phase(phase), .hit(hit), .ib(ib_q),
        .cw(ctrl_word), .done(done), .hold(hold)
    );

    always_comb begin
        ib_d = ib_q;
        if (ctrl_word[B_IRH_WR]) ib_d.hi = data_in;
        if (ctrl_word[B_IRL_WR]) ib_d.lo = data_in;
    end

    always_ff @(posedge clk) begin
        if (rst) ib_q <= '0;
        else     ib_q <= ib_d;
    end

    assign instr_hi = ib_q.hi;
    assign instr_lo = ib_q.lo;

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word & RSVD_MASK) == '0 && !ctrl_word[B_IP_WR]);

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[B_STOP] |=> ctrl_word[B_STOP]);

    // R2
    fetch_hi_chk: assert property (@(posedge clk) disable iff (rst)
        phase[0] |=> instr_hi == $past(data_in));

    // R2
    fetch_lo_chk: assert property (@(posedge clk) disable iff (rst)
        phase[1] |=> instr_lo == $past(data_in) && $stable(instr_hi));
endmodule

// File: tb/tb_ring_seq_ctrl.sv
module tb_ring_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [31:0] ctrl_word;
    logic [7:0]  instr_hi, instr_lo;

    int checks = 0;
    int fails  = 0;
    int m_st = 0;
    logic [7:0] m_hi = 8'h00, m_lo = 8'h00;

    ring_seq_ctrl dut (
        .clk(clk), .rst(rst), .data_in(data_in),
        .ctrl_word(ctrl_word), .instr_hi(instr_hi), .instr_lo(instr_lo)
    );

    always #4 clk = ~clk;

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic [31:0] exp_word(int st, logic [7:0] hi, logic [7:0] lo);
        logic [31:0] w;
        w = 32'h0;
        if (st == 0) return 32'h0080_0182;
        if (st == 1) return 32'h0300_0182;
        case (hi[7:4])
            4'h1: if (st == 2) w = 32'h8000_0000;
            4'h2: if (st == 2) w = 32'h0200_0C02 | (32'(lo[7:4]) << 12);
                  else if (st == 3) w = 32'h0400_0200 | (32'(hi[3:0]) << 12);
            4'h3: if (st == 2) w = 32'h0200_0400 | (32'(lo[7:4]) << 12);
                  else if (st == 3) w = 32'h0400_0C01 | (32'(hi[3:0]) << 12);
            4'h4: if (st == 2) w = 32'h0400_0200 | (32'(hi[3:0]) << 12);
            4'h5: if (st == 2) w = 32'h0020_0400 | (32'(lo[7:4]) << 12);
                  else if (st == 3) w = 32'h0040_0400 | (32'(lo[3:0]) << 12);
                  else if (st == 4) w = 32'h0001_0200 | (32'(hi[3:0]) << 12);
            default: w = 32'h0;
        endcase
        return w;
    endfunction

    function automatic int last_st(logic [3:0] opc);
        case (opc)
            4'h2, 4'h3: return 3;
            4'h5:       return 4;
            default:    return 2;
        endcase
    endfunction

    function automatic string req_of(int st, logic [3:0] opc);
        if (st < 2) return "R2";
        case (opc)
            4'h1: return "R3";
            4'h2: return "R4";
            4'h3: return "R5";
            4'h4: return "R6";
            4'h5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic cycle(logic [7:0] d);
        string rq;
        data_in = d;
        rq = req_of(m_st, m_hi[7:4]);
        chk(rq, "ctrl_word", ctrl_word, exp_word(m_st, m_hi, m_lo));
        chk("R9", "reserved bits", ctrl_word & 32'h7800_007C, 32'h0);
        chk(rq, "instr_hi", {24'h0, instr_hi}, {24'h0, m_hi});
        chk(rq, "instr_lo", {24'h0, instr_lo}, {24'h0, m_lo});
        @(posedge clk);
        if (m_st == 0) begin
            m_hi = d; m_st = 1;
        end else if (m_st == 1) begin
            m_lo = d; m_st = 2;
        end else if (m_hi[7:4] == 4'h1) begin
            m_st = 2;
        end else if (m_st == last_st(m_hi[7:4])) begin
            m_st = 0;
        end else begin
            m_st++;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "ctrl_word in reset", ctrl_word, 32'h0080_0182);
        rst = 1'b0;
        m_st = 0; m_hi = 8'h00; m_lo = 8'h00;
        chk("R1", "instr_hi after reset", {24'h0, instr_hi}, 32'h0);
        chk("R1", "instr_lo after reset", {24'h0, instr_lo}, 32'h0);
    endtask

    task automatic run_instr(logic [7:0] hi, logic [7:0] lo);
        cycle(hi);
        cycle(lo);
        while (m_st != 0 && !(m_hi[7:4] == 4'h1)) cycle(8'($urandom));
        if (m_hi[7:4] == 4'h1) begin
            for (int i = 0; i < 4; i++) cycle(8'($urandom)); // R3 hold
            do_reset();
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();
        // directed program, then unknown opcodes back to back, then halt
        run_instr(8'h40, 8'hCE);
        run_instr(8'h41, 8'h80);
        run_instr(8'h22, 8'h00);
        run_instr(8'h43, 8'h01);
        run_instr(8'h52, 8'h23);
        run_instr(8'h31, 8'h20);
        run_instr(8'hF0, 8'h00);   // R8
        run_instr(8'h00, 8'hFF);   // R8
        run_instr(8'h5F, 8'hFF);   // R7 all-ones indices
        run_instr(8'h6A, 8'h55);   // R8
        run_instr(8'h10, 8'h00);   // R3
        // random stream
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] h;
            h = 8'($urandom);
            if (h[7:4] == 4'h1 && ($urandom % 4) != 0) h[7:4] = 4'h5;
            run_instr(h, 8'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule